// File: doc/BRIEF.md
# DMA Page Translator

This block sits between the DMA channels and main memory and turns each 24-bit logical DMA address into a 29-bit physical address. Translation goes through one level of page table held in system memory. Pages are 4 KB. The upper 12 bits of the logical address select a page-table entry, and the low 12 bits go through unchanged as the offset into the page. Each entry takes 8 bytes, and its first 32-bit word holds the page-aligned physical frame.

Software sets up a table base address and a table size in bytes. It then writes the flush register after every change to the table. A small fully associative translation buffer keeps recent entries. A hit is answered one cycle after the request is accepted. On a miss, the block issues one 32-bit read at base + index*8 and keeps the channel stalled until the read returns. It then answers and caches the entry. A lookup whose entry lies at or past the table size gets an invalid-address fault. A read error during a table fetch gets a separate fetch-fail fault. For each kind of fault, the offending logical address is latched on an output.

Top module: `dmaPageXlate`

## Requirements
- R1: After reset, `reqReady`=1, `rspValid`=0, `memRdReq`=0, both fault flags are 0, and both fault address outputs are 0.
- R2: `cfgSel`=0 writes the table base and `cfgSel`=1 writes the table size in bytes. A request is accepted when `reqValid` and `reqReady` are both high. If the accepted request has index*8 >= size, `rspValid` and `rspInvFault` are high in the next cycle, no table read is issued, and `invFaultAddr` takes the full logical address.
- R3: When an accepted request misses, `memRdReq` rises in the next cycle with `memRdAddr` = base + index*8. The request and the address stay unchanged, and `reqReady` stays low, until a cycle with `memRdValid` high.
- R4: When the table read completes without error, `rspValid` is high in the next cycle with `rspPaddr` = {`memRdData[28:12]`, logical offset}, and both fault flags are low.
- R5: A request to a page already held in the buffer is answered one cycle after acceptance, with no table read.
- R6: When a table read returns with `memRdErr`=1, the response carries `rspFailFault` and `failFaultAddr` takes the logical address. The entry is not cached, so the next request to that page fetches again.
- R7: `cfgSel`=2 is the flush register. Any write to it, whatever the data (including 0), discards every cached translation, so the next request to a previously cached page fetches again.
- R8: If a flush is written while a table read is outstanding, the response for that read is still delivered, but the entry is not cached.
- R9: The buffer holds 4 entries and fills them in round-robin order, starting at entry 0 after reset, whether or not an entry is valid. The fifth distinct fill evicts the first page that was filled.
- R10: Bits 31:29 and 11:0 of the table word have no effect on the physical address, and the page offset is passed through unchanged.
- R11: A request accepted in the same cycle as a flush write does not hit. It fetches from the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 base, 1 size, 2 flush |
| cfgWrData | input | 32 | Configuration write data |
| reqValid | input | 1 | Translation request from a channel |
| reqLaddr | input | 24 | Logical address of the request |
| reqReady | output | 1 | Block can accept a request |
| rspValid | output | 1 | Response valid (one cycle) |
| rspPaddr | output | 29 | Physical address (0 on a fault) |
| rspInvFault | output | 1 | Response is an invalid-address fault |
| rspFailFault | output | 1 | Response is a fetch-fail fault |
| memRdReq | output | 1 | Table read request, held until the data returns |
| memRdAddr | output | 32 | Table read byte address |
| memRdValid | input | 1 | Table read data valid |
| memRdData | input | 32 | Table read data (frame word) |
| memRdErr | input | 1 | Table read failed |
| invFaultAddr | output | 24 | Latched address of the last invalid-address fault |
| failFaultAddr | output | 24 | Latched address of the last fetch-fail fault |

## Verification
The bench aims at the boundary entry just below the size limit and the one at it. A design with an off-by-one comparison would either fetch for the forbidden entry or fault on the last legal one. Eviction order is checked by filling five distinct pages and probing which ones still hit; a replacement policy that preferred invalid slots or hashed the index would evict a different page. Flushes are placed before a lookup, in the same cycle as an acceptance, and in the middle of an outstanding read. A design that kept stale state would answer from the buffer instead of fetching. A read error must leave no entry behind, otherwise a retry would wrongly hit on a failed fetch.

// File: rtl/dmaPageXlatePkg.sv
package dmaPageXlatePkg;

  localparam logic [1:0] SEL_BASE  = 2'd0;
  localparam logic [1:0] SEL_LIMIT = 2'd1;
  localparam logic [1:0] SEL_FLUSH = 2'd2;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } xlState_e;

  // strobes from control to datapath, at most one response kind per cycle
  typedef struct packed {
    logic hitRsp;
    logic invRsp;
    logic startFetch;
    logic fillRsp;
    logic failRsp;
  } ctrlStrobeT;

endpackage

// File: rtl/dmaPageXlateCtrl.sv
module dmaPageXlateCtrl
  import dmaPageXlatePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       limitMiss,
  input  logic       tlbHit,
  input  logic       memRdValid,
  input  logic       memRdErr,
  output logic       reqReady,
  output logic       memRdReq,
  output ctrlStrobeT strobes
);

  xlState_e stateQ, stateD;
  logic     accept;

  assign reqReady = (stateQ == ST_IDLE);
  assign memRdReq = (stateQ == ST_FETCH);
  assign accept   = reqValid && reqReady;

  always_comb begin
    strobes            = '0;
    stateD             = stateQ;
    strobes.invRsp     = accept && limitMiss;
    strobes.hitRsp     = accept && !limitMiss && tlbHit;
    strobes.startFetch = accept && !limitMiss && !tlbHit;
    if (strobes.startFetch) stateD = ST_FETCH;
    if (stateQ == ST_FETCH && memRdValid) begin
      strobes.fillRsp = !memRdErr;
      strobes.failRsp = memRdErr;
      stateD          = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R3: table read held until the data returns
  a_r3_hold_read: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq && !memRdValid |=> memRdReq);

  // R3: no new request accepted during a fetch
  a_r3_busy_stall: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> !reqReady);

  // R2: a limit fault never starts a table read
  a_r2_no_fetch_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && limitMiss |=> !memRdReq);

endmodule

// File: rtl/dmaPageXlateDp.sv
module dmaPageXlateDp
  import dmaPageXlatePkg::*;
#(
  parameter int LADDR_W   = 24,
  parameter int PADDR_W   = 29,
  parameter int PAGE_W    = 12,
  parameter int MEM_W     = 32,
  parameter int PTE_SHIFT = 3,
  parameter int ENTRIES   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [1:0]         cfgSel,
  input  logic [MEM_W-1:0]   cfgWrData,
  input  logic [LADDR_W-1:0] reqLaddr,
  input  ctrlStrobeT         strobes,
  input  logic               memRdReq,
  input  logic               memRdValid,
  input  logic [MEM_W-1:0]   memRdData,
  output logic               limitMiss,
  output logic               tlbHit,
  output logic               rspValid,
  output logic [PADDR_W-1:0] rspPaddr,
  output logic               rspInvFault,
  output logic               rspFailFault,
  output logic [MEM_W-1:0]   memRdAddr,
  output logic [LADDR_W-1:0] invFaultAddr,
  output logic [LADDR_W-1:0] failFaultAddr
);

  localparam int IDX_W   = LADDR_W - PAGE_W;
  localparam int FRAME_W = PADDR_W - PAGE_W;
  localparam int PTR_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [MEM_W-1:0]   cfgBase, cfgLimit;
  logic               flushWr;
  logic [IDX_W-1:0]   reqIdx;
  logic [MEM_W-1:0]   entOff;
  logic [FRAME_W-1:0] memFrame, hitFrame;
  logic [LADDR_W-1:0] pendLaddr;
  logic               fillOk, doFill;

  logic [IDX_W-1:0]   tagQ   [ENTRIES];
  logic [FRAME_W-1:0] frameQ [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] matchVec;
  logic [PTR_W-1:0]   victimQ;

  logic unusedBits;
  assign unusedBits = ^{memRdData[MEM_W-1:PADDR_W], memRdData[PAGE_W-1:0]};

  assign flushWr   = cfgWrEn && (cfgSel == SEL_FLUSH);
  assign reqIdx    = reqLaddr[LADDR_W-1:PAGE_W];
  assign entOff    = MEM_W'(reqIdx) << PTE_SHIFT;
  assign limitMiss = (entOff >= cfgLimit);
  assign memFrame  = memRdData[PADDR_W-1:PAGE_W];
  assign doFill    = strobes.fillRsp && fillOk && !flushWr;

  // tag compare, one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign matchVec[g] = validQ[g] && (tagQ[g] == reqIdx);
  end

  always_comb begin
    hitFrame = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (matchVec[i]) hitFrame |= frameQ[i];
  end

  // a flush in the same cycle hides every entry from the lookup
  assign tlbHit = (|matchVec) && !flushWr;

  // configuration, response and fetch registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBase       <= '0;
      cfgLimit      <= '0;
      rspValid      <= 1'b0;
      rspPaddr      <= '0;
      rspInvFault   <= 1'b0;
      rspFailFault  <= 1'b0;
      memRdAddr     <= '0;
      pendLaddr     <= '0;
      invFaultAddr  <= '0;
      failFaultAddr <= '0;
      fillOk        <= 1'b0;
    end else begin
      if (cfgWrEn && cfgSel == SEL_BASE)  cfgBase  <= cfgWrData;
      if (cfgWrEn && cfgSel == SEL_LIMIT) cfgLimit <= cfgWrData;

      rspValid     <= strobes.hitRsp || strobes.invRsp ||
                      strobes.fillRsp || strobes.failRsp;
      rspInvFault  <= strobes.invRsp;
      rspFailFault <= strobes.failRsp;

      if (strobes.hitRsp)
        rspPaddr <= {hitFrame, reqLaddr[PAGE_W-1:0]};
      else if (strobes.fillRsp)
        rspPaddr <= {memFrame, pendLaddr[PAGE_W-1:0]};
      else if (strobes.invRsp || strobes.failRsp)
        rspPaddr <= '0;

      if (strobes.invRsp)  invFaultAddr  <= reqLaddr;
      if (strobes.failRsp) failFaultAddr <= pendLaddr;

      if (flushWr) fillOk <= 1'b0;
      if (strobes.startFetch) begin
        memRdAddr <= cfgBase + entOff;
        pendLaddr <= reqLaddr;
        fillOk    <= 1'b1;
      end
    end
  end

  // translation buffer storage and round-robin victim pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ  <= '0;
      victimQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i]   <= '0;
        frameQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flushWr) validQ[i] <= 1'b0;
        else if (doFill && victimQ == PTR_W'(i)) begin
          validQ[i] <= 1'b1;
          tagQ[i]   <= pendLaddr[LADDR_W-1:PAGE_W];
          frameQ[i] <= memFrame;
        end
      end
      if (doFill)
        victimQ <= (victimQ == PTR_W'(ENTRIES - 1)) ? '0 : victimQ + 1'b1;
    end
  end

  // R3: fetch address stable while the read is outstanding
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq && !memRdValid |=> $stable(memRdAddr));

  // R7: a flush empties the buffer
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    flushWr |=> validQ == '0);

  // R2: fault flags only on a response and never both
  a_r2_fault_flags: assert property (@(posedge clk) disable iff (!rstN)
    (rspInvFault || rspFailFault) |-> rspValid && $onehot0({rspInvFault, rspFailFault}));

  // R9: a page is held in at most one entry
  a_r9_unique_tag: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

endmodule

// File: rtl/dmaPageXlate.sv
module dmaPageXlate
  import dmaPageXlatePkg::*;
#(
  parameter int LADDR_W   = 24,
  parameter int PADDR_W   = 29,
  parameter int PAGE_W    = 12,
  parameter int MEM_W     = 32,
  parameter int PTE_SHIFT = 3,
  parameter int ENTRIES   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [1:0]         cfgSel,
  input  logic [MEM_W-1:0]   cfgWrData,
  input  logic               reqValid,
  input  logic [LADDR_W-1:0] reqLaddr,
  output logic               reqReady,
  output logic               rspValid,
  output logic [PADDR_W-1:0] rspPaddr,
  output logic               rspInvFault,
  output logic               rspFailFault,
  output logic               memRdReq,
  output logic [MEM_W-1:0]   memRdAddr,
  input  logic               memRdValid,
  input  logic [MEM_W-1:0]   memRdData,
  input  logic               memRdErr,
  output logic [LADDR_W-1:0] invFaultAddr,
  output logic [LADDR_W-1:0] failFaultAddr
);

  ctrlStrobeT strobes;
  logic       limitMiss, tlbHit;

  dmaPageXlateCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .limitMiss  (limitMiss),
    .tlbHit     (tlbHit),
    .memRdValid (memRdValid),
    .memRdErr   (memRdErr),
    .reqReady   (reqReady),
    .memRdReq   (memRdReq),
    .strobes    (strobes)
  );

  dmaPageXlateDp #(
    .LADDR_W   (LADDR_W),
    .PADDR_W   (PADDR_W),
    .PAGE_W    (PAGE_W),
    .MEM_W     (MEM_W),
    .PTE_SHIFT (PTE_SHIFT),
    .ENTRIES   (ENTRIES)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .cfgWrEn       (cfgWrEn),
    .cfgSel        (cfgSel),
    .cfgWrData     (cfgWrData),
    .reqLaddr      (reqLaddr),
    .strobes       (strobes),
    .memRdReq      (memRdReq),
    .memRdValid    (memRdValid),
    .memRdData     (memRdData),
    .limitMiss     (limitMiss),
    .tlbHit        (tlbHit),
    .rspValid      (rspValid),
    .rspPaddr      (rspPaddr),
    .rspInvFault   (rspInvFault),
    .rspFailFault  (rspFailFault),
    .memRdAddr     (memRdAddr),
    .invFaultAddr  (invFaultAddr),
    .failFaultAddr (failFaultAddr)
  );

endmodule

// File: tb/dmaPageXlate_tb_top.sv
module dmaPageXlate_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [31:0] cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic [23:0] reqLaddr = '0;
  logic        reqReady, rspValid, rspInvFault, rspFailFault, memRdReq;
  logic [28:0] rspPaddr;
  logic [31:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        memRdErr = 1'b0;
  logic [23:0] invFaultAddr, failFaultAddr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dmaPageXlate dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqLaddr(reqLaddr), .reqReady(reqReady),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspInvFault(rspInvFault),
    .rspFailFault(rspFailFault), .memRdReq(memRdReq), .memRdAddr(memRdAddr),
    .memRdValid(memRdValid), .memRdData(memRdData), .memRdErr(memRdErr),
    .invFaultAddr(invFaultAddr), .failFaultAddr(failFaultAddr)
  );

  // results of the last request
  logic        gotFetch, gotRsp, holdOk, gotInv, gotFail;
  logic [31:0] gotAddr;
  logic [28:0] gotPaddr;
  logic [31:0] baseCur = 32'h0010_0000;

  function automatic logic [16:0] frameOf(input logic [11:0] idx);
    return {5'h15, idx} ^ 17'h0A5A5;
  endfunction

  // table word: garbage in bits 31:29 and 11:0
  function automatic logic [31:0] pteWord(input logic [31:0] addr);
    logic [31:0] idx;
    idx = (addr - baseCur) >> 3;
    return {3'b111, frameOf(idx[11:0]), 12'hFED};
  endfunction

  function automatic logic [28:0] expPa(input logic [23:0] la);
    return {frameOf(la[23:12]), la[11:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic runReq(input logic [23:0] la, input int waitCyc, input bit errInj,
                        input bit flushMid, input bit flushSame);
    int w;
    @(negedge clk);
    reqValid = 1'b1; reqLaddr = la;
    if (flushSame) begin cfgWrEn = 1'b1; cfgSel = 2'd2; cfgWrData = 32'h0; end
    @(negedge clk);
    reqValid = 1'b0; cfgWrEn = 1'b0;
    gotFetch = 1'b0; gotRsp = 1'b0; holdOk = 1'b1; w = 0;
    for (int n = 0; n < 40 && !gotRsp; n++) begin
      if (rspValid) begin
        gotRsp = 1'b1; gotPaddr = rspPaddr; gotInv = rspInvFault; gotFail = rspFailFault;
      end else begin
        if (memRdReq) begin
          if (!gotFetch) begin gotFetch = 1'b1; gotAddr = memRdAddr; end
          else if (memRdAddr != gotAddr) holdOk = 1'b0;
          if (reqReady) holdOk = 1'b0;
          if (w >= waitCyc) begin
            memRdValid = 1'b1; memRdData = pteWord(memRdAddr); memRdErr = errInj;
          end else if (flushMid && w == 0) begin
            cfgWrEn = 1'b1; cfgSel = 2'd2; cfgWrData = 32'h1234;
          end
          w++;
        end
        @(negedge clk);
        memRdValid = 1'b0; memRdErr = 1'b0; cfgWrEn = 1'b0;
      end
    end
    chk(gotRsp, "R4", "response seen", {31'b0, gotRsp}, 32'h1);
  endtask

  // vector: laddr, expect fetch, expect invalid-address fault
  localparam int NVEC = 13;
  localparam logic [25:0] VEC [NVEC] = '{
    {24'h000123, 1'b1, 1'b0},   // R4 idx0 fill slot0
    {24'h000FFF, 1'b0, 1'b0},   // R5 hit, R10 offset
    {24'h0FF010, 1'b1, 1'b0},   // R2 last legal entry
    {24'h100000, 1'b0, 1'b1},   // R2 first entry at limit
    {24'h001800, 1'b1, 1'b0},
    {24'h002004, 1'b1, 1'b0},   // buffer full
    {24'h0FF7FF, 1'b0, 1'b0},
    {24'h003000, 1'b1, 1'b0},   // R9 evicts idx0
    {24'h000500, 1'b1, 1'b0},   // R9 idx0 gone
    {24'h001ABC, 1'b0, 1'b0},
    {24'h0FF000, 1'b1, 1'b0},   // R9 idx255 was evicted
    {24'hFFFFFF, 1'b0, 1'b1},
    {24'h002FFF, 1'b0, 1'b0}
  };

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    chk(1'b0, "WATCHDOG", "run hung", cycles, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reqReady === 1'b1, "R1", "reqReady", {31'b0, reqReady}, 1);
    chk(rspValid === 1'b0 && memRdReq === 1'b0, "R1", "rspValid/memRdReq",
        {30'b0, rspValid, memRdReq}, 0);
    chk(rspInvFault === 1'b0 && rspFailFault === 1'b0, "R1", "fault flags",
        {30'b0, rspInvFault, rspFailFault}, 0);
    chk(invFaultAddr === 24'h0 && failFaultAddr === 24'h0, "R1", "fault addrs",
        {8'b0, invFaultAddr ^ failFaultAddr}, 0);
    rstN = 1'b1;

    cfgWrite(2'd0, baseCur);
    cfgWrite(2'd1, 32'h800);  // 256 entries

    for (int v = 0; v < NVEC; v++) begin
      logic [23:0] la;
      la = VEC[v][25:2];
      runReq(la, 0, 1'b0, 1'b0, 1'b0);
      chk(gotFetch == VEC[v][1], "R9", $sformatf("vec%0d fetch", v), {31'b0, gotFetch}, {31'b0, VEC[v][1]});
      chk(gotInv == VEC[v][0] && !gotFail, "R2", $sformatf("vec%0d fault", v), {31'b0, gotInv}, {31'b0, VEC[v][0]});
      if (VEC[v][1])
        chk(gotAddr == baseCur + {17'b0, la[23:12], 3'b0}, "R3", $sformatf("vec%0d fetch addr", v),
            gotAddr, baseCur + {17'b0, la[23:12], 3'b0});
      if (VEC[v][0])
        chk(invFaultAddr == la, "R2", "invFaultAddr", {8'b0, invFaultAddr}, {8'b0, la});
      else
        chk(gotPaddr == expPa(la), "R10", $sformatf("vec%0d paddr", v), {3'b0, gotPaddr}, {3'b0, expPa(la)});
    end

    // R7: flush with data 0, cached page must fetch again
    cfgWrite(2'd2, 32'h0);
    runReq(24'h002FFF, 0, 1'b0, 1'b0, 1'b0);
    chk(gotFetch, "R7", "fetch after flush", {31'b0, gotFetch}, 1);

    // R3: stalled read keeps request, address and stall
    runReq(24'h004010, 3, 1'b0, 1'b0, 1'b0);
    chk(holdOk, "R3", "hold during stall", {31'b0, holdOk}, 1);
    chk(gotAddr == baseCur + 32'h20, "R3", "stall fetch addr", gotAddr, baseCur + 32'h20);
    chk(gotPaddr == expPa(24'h004010), "R4", "paddr after stall", {3'b0, gotPaddr}, {3'b0, expPa(24'h004010)});

    // R6: read error, then retry fetches again
    runReq(24'h005123, 0, 1'b1, 1'b0, 1'b0);
    chk(gotFail && !gotInv, "R6", "fail fault", {30'b0, gotFail, gotInv}, 32'h2);
    chk(failFaultAddr == 24'h005123, "R6", "failFaultAddr", {8'b0, failFaultAddr}, 32'h005123);
    runReq(24'h005000, 0, 1'b0, 1'b0, 1'b0);
    chk(gotFetch, "R6", "refetch after error", {31'b0, gotFetch}, 1);
    chk(!gotFail && gotPaddr == expPa(24'h005000), "R6", "retry paddr", {3'b0, gotPaddr}, {3'b0, expPa(24'h005000)});

    // R8: flush during an outstanding read
    runReq(24'h006040, 2, 1'b0, 1'b1, 1'b0);
    chk(gotPaddr == expPa(24'h006040) && !gotFail && !gotInv, "R8", "delivered",
        {3'b0, gotPaddr}, {3'b0, expPa(24'h006040)});
    runReq(24'h006000, 0, 1'b0, 1'b0, 1'b0);
    chk(gotFetch, "R8", "not cached", {31'b0, gotFetch}, 1);
    runReq(24'h006444, 0, 1'b0, 1'b0, 1'b0);
    chk(!gotFetch, "R5", "hit after fill", {31'b0, gotFetch}, 0);

    // R11: flush in the acceptance cycle
    runReq(24'h006000, 0, 1'b0, 1'b0, 1'b1);
    chk(gotFetch, "R11", "no hit with same-cycle flush", {31'b0, gotFetch}, 1);

    // R2: shrink table to 5 entries
    cfgWrite(2'd1, 32'h28);
    runReq(24'h005000, 0, 1'b0, 1'b0, 1'b0);
    chk(gotInv && !gotFetch, "R2", "limit boundary", {30'b0, gotInv, gotFetch}, 32'h2);
    chk(invFaultAddr == 24'h005000, "R2", "invFaultAddr", {8'b0, invFaultAddr}, 32'h005000);
    runReq(24'h004ABC, 0, 1'b0, 1'b0, 1'b0);
    chk(!gotInv && gotPaddr == expPa(24'h004ABC), "R2", "below limit", {3'b0, gotPaddr}, {3'b0, expPa(24'h004ABC)});

    // R3: new base moves the fetch address
    baseCur = 32'h0020_0000;
    cfgWrite(2'd0, baseCur);
    cfgWrite(2'd2, 32'hFFFF_FFFF);
    runReq(24'h003000, 0, 1'b0, 1'b0, 1'b0);
    chk(gotFetch && gotAddr == 32'h0020_0018, "R3", "new base addr", gotAddr, 32'h0020_0018);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule